// File: doc/BRIEF.md
# Sticky Interrupt Aggregator With Conditional Clear

This block merges four interrupt sources into one active-low interrupt line for a host processor. Each source has a pending flag that is set by a one-cycle event pulse. The flag then holds until its own clear rule is met. A four-bit enable register decides which pending flags may pull the line low. Disabling a source hides its flag from the output but leaves the flag in place.

The host releases a source by reading the status register tied to it. A read is a strobe plus a two-bit select, and select value k belongs to source k. Sources 0 and 1 clear on that read. Source 2 reports result data and source 3 reports a full storage array. For these two sources the read only arms the clear. The flag drops in the first cycle, counted from the read onward, in which the result-remaining count is zero (source 2) or the storage is no longer full (source 3).

Top module: `irq_agg`

## Requirements
- R1: After reset is asserted (rst_ni low, asynchronous), all enables and pending flags are zero and irq_no_o is 1. An event that arrives before any enable write leaves irq_no_o at 1.
- R2: A cycle with cfg_we_i=1 loads cfg_en_i into the enable register, where bit k enables source k. An event pulse on evt_i[k] for an enabled source drives irq_no_o to 0 right after that clock edge.
- R3: irq_no_o is 0 while at least one enabled source is pending. It returns to 1 only after every enabled pending source has cleared.
- R4: A pending flag holds across idle cycles and across reads whose select does not match its index.
- R5: For sources 0 and 1, a cycle with rd_stb_i=1 and rd_sel_i equal to the source index clears the pending flag at that edge.
- R6: For source 2, a matching read made while res_left_i is nonzero does not clear the flag but arms the clear. The flag drops at the first later edge where res_left_i is zero. A matching read with res_left_i zero clears the flag at once.
- R7: For source 3, a matching read while store_full_i=1 does not clear the flag but arms the clear. The flag drops at the first later edge where store_full_i=0. store_full_i falling with no prior read leaves the flag pending.
- R8: Clearing a source's enable bit forces its contribution to irq_no_o to 1 but keeps its flag. Setting the bit again brings back the 0 on irq_no_o.
- R9: If an event and a clearing read for the same source happen in one cycle, the flag stays pending.
- R10: A matching read made while the source is not pending arms nothing. A later event is not cleared by the qualifier alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Enable register write strobe |
| cfg_en_i | input | 4 | New enable bits, bit k for source k |
| evt_i | input | 4 | Event pulses, bit k for source k |
| rd_stb_i | input | 1 | Status register read strobe |
| rd_sel_i | input | 2 | Index of the status register read |
| res_left_i | input | RES_W (8) | Count of result words still unread |
| store_full_i | input | 1 | Storage array is full |
| irq_no_o | output | 1 | Interrupt, active low |

## Verification
The bench checks that a status read with a wrong select does not clear a flag, so a loose decode shows up as an early release. It holds the result count above zero and the storage full across a read, then lets each qualifier go away with no further read. A design that cleared on the read alone would release too early. A design that had no armed state would never release. The bench lets the storage leave the full state before any read, then makes a read while nothing is pending followed by a new event. A design that armed in either case would drop the line without a valid read. It also checks that the set wins when an event meets its own clearing read, that a masked flag survives and shows again, and that reset taken in the middle of a run clears everything.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_COND = 4;
  localparam int SEL_W = $clog2(NUM_COND);
  localparam int COND_RESULT = 2;
  localparam int COND_STORE = 3;

  typedef enum logic [1:0] {
    CLR_PLAIN  = 2'd0,
    CLR_RESULT = 2'd1,
    CLR_STORE  = 2'd2
  } clr_mode_e;

  function automatic clr_mode_e mode_of(int idx);
    if (idx == COND_RESULT) return CLR_RESULT;
    if (idx == COND_STORE) return CLR_STORE;
    return CLR_PLAIN;
  endfunction
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg
  import irq_agg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [NUM_COND-1:0] wdata_i,
  output logic [NUM_COND-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= '0;
    else if (we_i) en_o <= wdata_i;
  end

  // R2
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_o));
endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
  import irq_agg_pkg::*;
#(
  parameter int        IDX  = 0,
  parameter clr_mode_e MODE = CLR_PLAIN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             rd_stb_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  input  logic             qual_ok_i,
  output logic             pend_o
);
  logic hit, clr;

  assign hit = rd_stb_i && (rd_sel_i == SEL_W'(IDX));

  generate
    if (MODE == CLR_PLAIN) begin : g_plain
      assign clr = pend_o && hit;

      // R5
      plain_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_o && hit && !evt_i |=> !pend_o);
      // R4
      plain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_o && !hit |=> pend_o);
    end else begin : g_qual
      logic arm_q;
      // read arms the clear; it completes once the qualifier allows
      assign clr = pend_o && (hit || arm_q) && qual_ok_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) arm_q <= 1'b0;
        else if (clr) arm_q <= 1'b0;
        else if (hit && pend_o) arm_q <= 1'b1;
      end

      // R6 R7
      qual_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_o && !qual_ok_i |=> pend_o);
      // R10
      no_arm_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pend_o && !arm_q |=> !arm_q);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else pend_o <= evt_i || (pend_o && !clr);
  end

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> pend_o);
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import irq_agg_pkg::*;
(
  input  logic [NUM_COND-1:0] pend_i,
  input  logic [NUM_COND-1:0] en_i,
  output logic                irq_no_o
);
  assign irq_no_o = ~|(pend_i & en_i);
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [NUM_COND-1:0] cfg_en_i,
  input  logic [NUM_COND-1:0] evt_i,
  input  logic                rd_stb_i,
  input  logic [SEL_W-1:0]    rd_sel_i,
  input  logic [RES_W-1:0]    res_left_i,
  input  logic                store_full_i,
  output logic                irq_no_o
);
  logic [NUM_COND-1:0] en, pend, qual;

  irq_en_reg i_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_en_i),
    .en_o    (en)
  );

  for (genvar k = 0; k < NUM_COND; k++) begin : g_cond
    localparam clr_mode_e M = mode_of(k);
    if (M == CLR_RESULT) begin : g_q
      assign qual[k] = (res_left_i == '0);
    end else if (M == CLR_STORE) begin : g_q
      assign qual[k] = !store_full_i;
    end else begin : g_q
      assign qual[k] = 1'b1;
    end

    irq_pend_cell #(.IDX(k), .MODE(M)) i_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[k]),
      .rd_stb_i  (rd_stb_i),
      .rd_sel_i  (rd_sel_i),
      .qual_ok_i (qual[k]),
      .pend_o    (pend[k])
    );
  end

  irq_merge i_merge (
    .pend_i   (pend),
    .en_i     (en),
    .irq_no_o (irq_no_o)
  );

  // R8
  masked_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> irq_no_o);
  // R3
  pend_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no_o |-> (pend != '0));
endmodule

// File: tb/test_irq_agg.sv
`timescale 1ns/1ps
module test_irq_agg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] wd = '0;
  logic [3:0] evt = '0;
  logic       rd = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] left = '0;
  logic       full = 1'b0;
  logic       irq_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_agg i_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_en_i(wd), .evt_i(evt),
    .rd_stb_i(rd), .rd_sel_i(sel), .res_left_i(left), .store_full_i(full),
    .irq_no_o(irq_n)
  );

  typedef struct packed {
    logic       we;
    logic [3:0] wd;
    logic [3:0] evt;
    logic       rd;
    logic [1:0] sel;
    logic [7:0] left;
    logic       full;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  // fields: we, wd, evt, rd, sel, left, full, exp, req
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'b0001, 4'b0000, 1'b0, 2'd0, 8'd0, 1'b0, 1'b1, 4'd2},  // R2 enable alone
    '{1'b0, 4'b0000, 4'b0001, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 4'd2},  // R2 event
    '{1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 4'd4},  // R4 idle hold
    '{1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1, 8'd0, 1'b0, 1'b0, 4'd4},  // R4 wrong select
    '{1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0, 8'd0, 1'b0, 1'b1, 4'd5},  // R5 clear
    '{1'b1, 4'b0100, 4'b0100, 1'b0, 2'd0, 8'd3, 1'b0, 1'b0, 4'd6},  // R6 set
    '{1'b0, 4'b0000, 4'b0000, 1'b1, 2'd2, 8'd3, 1'b0, 1'b0, 4'd6},  // R6 read, data left
    '{1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 8'd1, 1'b0, 1'b0, 4'd6},  // R6 still left
    '{1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 8'd0, 1'b0, 1'b1, 4'd6},  // R6 drained
    '{1'b1, 4'b1000, 4'b1000, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 4'd7},  // R7 set
    '{1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 4'd7},  // R7 not full, no read
    '{1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3, 8'd0, 1'b1, 1'b0, 4'd7},  // R7 read while full
    '{1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 4'd7},  // R7 still full
    '{1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 8'd0, 1'b0, 1'b1, 4'd7},  // R7 left full
    '{1'b1, 4'b0000, 4'b0010, 1'b0, 2'd0, 8'd0, 1'b0, 1'b1, 4'd8},  // R8 masked event
    '{1'b1, 4'b0010, 4'b0000, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 4'd8},  // R8 unmask
    '{1'b0, 4'b0000, 4'b0010, 1'b1, 2'd1, 8'd0, 1'b0, 1'b0, 4'd9},  // R9 set wins
    '{1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1, 8'd0, 1'b0, 1'b1, 4'd5},  // R5 clear
    '{1'b1, 4'b0100, 4'b0000, 1'b1, 2'd2, 8'd0, 1'b0, 1'b1, 4'd10}, // R10 idle read
    '{1'b0, 4'b0000, 4'b0100, 1'b0, 2'd0, 8'd2, 1'b0, 1'b0, 4'd10}, // R10 event
    '{1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 4'd10}, // R10 no arm
    '{1'b0, 4'b0000, 4'b0000, 1'b1, 2'd2, 8'd0, 1'b0, 1'b1, 4'd6},  // R6 immediate
    '{1'b1, 4'b0011, 4'b0011, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 4'd3},  // R3 two pending
    '{1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0, 8'd0, 1'b0, 1'b0, 4'd3},  // R3 one left
    '{1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1, 8'd0, 1'b0, 1'b1, 4'd3}   // R3 none left
  };

  task automatic check(input logic exp, input string req);
    checks++;
    if (irq_n !== exp) begin
      errors++;
      $display("FAIL %s irq_no_o=%b expected %b at %0t", req, irq_n, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] d, input logic [3:0] e,
                      input logic r, input logic [1:0] s, input logic [7:0] l,
                      input logic f);
    @(negedge clk);
    we = w; wd = d; evt = e; rd = r; sel = s; left = l; full = f;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check(1'b1, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(1'b1, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].we, VECS[i].wd, VECS[i].evt, VECS[i].rd, VECS[i].sel,
           VECS[i].left, VECS[i].full);
      checks++;
      if (irq_n !== VECS[i].exp) begin
        errors++;
        $display("FAIL R%0d vector %0d irq_no_o=%b expected %b",
                 VECS[i].req, i, irq_n, VECS[i].exp);
      end
    end

    // R1: reset in the middle of a run
    step(1'b1, 4'b0001, 4'b0001, 1'b0, 2'd0, 8'd0, 1'b0);
    check(1'b0, "R1 pending before reset");
    @(negedge clk);
    we = 1'b0; evt = '0;
    rst_n = 1'b0;
    #1;
    check(1'b1, "R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 4'b0000, 4'b0001, 1'b0, 2'd0, 8'd0, 1'b0);
    check(1'b1, "R1 enables cleared");
    step(1'b1, 4'b1111, 4'b0000, 1'b0, 2'd0, 8'd0, 1'b0);
    check(1'b0, "R1 flag set after reset still sticky");
    step(1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0, 8'd0, 1'b0);
    check(1'b1, "R5 clear after reset");

    step(1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 8'd0, 1'b0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule